// File: doc/BRIEF.md
# Half-to-Single Precision Widener

This block takes a 16-bit half-precision floating-point value and returns the 32-bit single-precision value of the same number. Each accepted input yields one registered result a cycle later. Two bits of a 32-bit floating-point control word set the behaviour:

- **Alternative half format.** This bit makes the top exponent code an ordinary finite exponent instead of infinity or NaN.
- **Default-NaN.** This bit replaces every NaN result with one canonical quiet NaN.

A half subnormal is renormalised with a leading-zero count. The widening is always exact, so it needs no rounding. The only exception it can raise is invalid-operation, from a signalling NaN input.

Exception handling follows the control word. Each exception code `k` has an enable at control bit `k + 8`. When that enable is clear, the exception sets bit `k` of a sticky status vector, and the bit stays set until reset. When the enable is set, the block instead pulses bit `k` of a trap-request vector for one cycle, aligned with the result. What happens after a trap request is left to the surrounding logic.

Top module: `half_widen`

## Requirements
- R1: `outValid` is high in the cycle after each cycle with `inValid` high, and `singleOut` then holds that input's result. Cycles with `inValid` low leave `singleOut` unchanged. Reset clears every output to zero.
- R2: An input with exponent field (bits 14:10) 0 and fraction (bits 9:0) 0 becomes a single zero that keeps the input sign (bit 15 goes to bit 31).
- R3: An input with exponent 0 and a nonzero fraction `f` is the subnormal `f × 2^-24`. Its result is exact and normalised: the single exponent is 112 minus the count of leading zeros in `f`, and so lies in 103..112.
- R4: An input with exponent 1..30, or any exponent when the alternative-format bit (control bit 26) is set, gives single exponent `e + 112` and fraction `f` placed at bits 22:13 with zeros below. With bit 26 set, exponent 31 gives exponent 143.
- R5: With control bit 26 clear, exponent 31 with fraction 0 gives single infinity of the same sign (`0x7F800000` or `0xFF800000`).
- R6: With control bits 26 and 25 clear, exponent 31 with a nonzero fraction is a NaN. The result is the input sign at bit 31, OR `0x7FC00000`, OR fraction bits 8:0 at bits 21:13, so the output NaN is always quiet.
- R7: With control bit 26 clear and control bit 25 set, every NaN input gives exactly `0x7FC00000`.
- R8: A NaN input whose fraction bit 9 is clear is signalling and raises invalid-operation (code 0). When control bit 8 is clear, this sets `stickyFlags[0]`, which stays set until reset. No other input and no other code ever sets a sticky bit.
- R9: When control bit 8 is set, a signalling NaN pulses `trapReq[0]` for exactly the output cycle of that input. `stickyFlags` is left unchanged. `trapReq` is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input value is present this cycle |
| halfIn | input | 16 | Half-precision input value |
| ctrlWord | input | 32 | Floating-point control word; bits 26, 25 and 15:8 are used |
| outValid | output | 1 | Result register loaded in the previous cycle |
| singleOut | output | 32 | Single-precision result |
| stickyFlags | output | 8 | Accumulated exception flags, indexed by exception code |
| trapReq | output | 8 | One-cycle trap requests, indexed by exception code |

## Verification
The assertions take `halfIn` and `ctrlWord` to be fully known whenever `inValid` is high. They also take the control word to be sampled with the data in the same cycle. The strobe-based properties are qualified by `inValid`, because the classification is meaningless on idle cycles. The bench changes inputs only on the falling clock edge and always drives complete two-state values. It covers every half code under both format settings, and it drops `inValid` on some cycles to check that the result is held.

// File: rtl/half_widen_pkg.sv
package half_widen_pkg;
  localparam int HALF_EXP_W  = 5;
  localparam int HALF_FRAC_W = 10;
  localparam int HALF_W      = 1 + HALF_EXP_W + HALF_FRAC_W;
  localparam int SGL_EXP_W   = 8;
  localparam int SGL_FRAC_W  = 23;
  localparam int SGL_W       = 1 + SGL_EXP_W + SGL_FRAC_W;
  localparam int HALF_BIAS   = (1 << (HALF_EXP_W - 1)) - 1;
  localparam int SGL_BIAS    = (1 << (SGL_EXP_W - 1)) - 1;
  localparam int BIAS_GAP    = SGL_BIAS - HALF_BIAS;
  localparam int PAD_W       = SGL_FRAC_W - HALF_FRAC_W;
  localparam int CTRL_W      = 32;
  localparam int DN_BIT      = 25;
  localparam int ALT_BIT     = 26;
  localparam int FLAG_W      = 8;
  localparam int TRAP_BASE   = 8;
  localparam int CODE_INVALID = 0;

  typedef enum logic [2:0] {
    KIND_ZERO,
    KIND_SUB,
    KIND_NORM,
    KIND_INF,
    KIND_NAN
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  defNan;
  } strobe_t;
endpackage

// File: rtl/half_widen_ctrl.sv
module half_widen_ctrl
  import half_widen_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [HALF_W-1:0]     halfIn,
  input  logic [CTRL_W-1:0]     ctrlWord,
  output strobe_t               strobes,
  output logic [FLAG_W-1:0]     stickyFlags,
  output logic [FLAG_W-1:0]     trapReq
);
  localparam logic [HALF_EXP_W-1:0] EXP_TOP = '1;

  logic [HALF_EXP_W-1:0]  expField;
  logic [HALF_FRAC_W-1:0] fracField;
  logic [FLAG_W-1:0]      raised;
  logic [FLAG_W-1:0]      trapEn;
  logic                   unusedCtrlBits;

  assign expField  = halfIn[HALF_W-2 -: HALF_EXP_W];
  assign fracField = halfIn[HALF_FRAC_W-1:0];
  assign trapEn    = ctrlWord[TRAP_BASE +: FLAG_W];
  assign unusedCtrlBits = ^{ctrlWord, halfIn[HALF_W-1]};

  always_comb begin
    strobes.defNan = ctrlWord[DN_BIT];
    if (expField == '0) begin
      strobes.kind = (fracField == '0) ? KIND_ZERO : KIND_SUB;
    end else if (expField == EXP_TOP && !ctrlWord[ALT_BIT]) begin
      strobes.kind = (fracField == '0) ? KIND_INF : KIND_NAN;
    end else begin
      strobes.kind = KIND_NORM;
    end
  end

  always_comb begin
    raised = '0;
    raised[CODE_INVALID] = inValid && (strobes.kind == KIND_NAN) &&
                           !fracField[HALF_FRAC_W-1];
  end

  for (genvar gi = 0; gi < FLAG_W; gi++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stickyFlags[gi] <= 1'b0;
        trapReq[gi]     <= 1'b0;
      end else begin
        trapReq[gi] <= raised[gi] & trapEn[gi];
        if (raised[gi] && !trapEn[gi]) stickyFlags[gi] <= 1'b1;
      end
    end
  end

  // R8: a sticky bit, once set, is never cleared before reset
  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((stickyFlags & $past(stickyFlags)) == $past(stickyFlags)));

  // R9: a trap request needs a valid input with its enable set one cycle earlier
  a_r9_trap_source: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq != '0) |-> $past(inValid && ctrlWord[TRAP_BASE + CODE_INVALID]));

  // R9: a trapped exception leaves the sticky bit untouched
  a_r9_trap_no_flag: assert property (@(posedge clk) disable iff (!rstN)
    trapReq[CODE_INVALID] |-> $stable(stickyFlags[CODE_INVALID]));
endmodule

// File: rtl/half_widen_dp.sv
module half_widen_dp
  import half_widen_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [HALF_W-1:0] halfIn,
  input  strobe_t           strobes,
  output logic              validQ,
  output logic [SGL_W-1:0]  resultQ
);
  localparam int LZ_W = $clog2(HALF_FRAC_W + 1);
  localparam logic [SGL_EXP_W-1:0] SUB_EXP_MAX = SGL_EXP_W'(BIAS_GAP);
  localparam logic [SGL_EXP_W-1:0] SUB_EXP_MIN = SGL_EXP_W'(BIAS_GAP - HALF_FRAC_W + 1);
  localparam logic [SGL_W-1:0] CANON_NAN =
    {1'b0, {SGL_EXP_W{1'b1}}, 1'b1, {(SGL_FRAC_W-1){1'b0}}};

  function automatic logic [LZ_W-1:0] lzCount(input logic [HALF_FRAC_W-1:0] v);
    logic [LZ_W-1:0] n;
    logic            seen;
    n = '0;
    seen = 1'b0;
    for (int i = HALF_FRAC_W - 1; i >= 0; i--) begin
      if (v[i]) seen = 1'b1;
      else if (!seen) n = n + 1'b1;
    end
    return n;
  endfunction

  logic                   signBit;
  logic [HALF_EXP_W-1:0]  expField;
  logic [HALF_FRAC_W-1:0] fracField;
  logic [LZ_W-1:0]        lz;
  logic [HALF_FRAC_W-1:0] subFrac;
  logic [SGL_EXP_W-1:0]   subExp;
  logic [SGL_EXP_W-1:0]   normExp;
  logic [SGL_W-1:0]       resultD;

  assign signBit   = halfIn[HALF_W-1];
  assign expField  = halfIn[HALF_W-2 -: HALF_EXP_W];
  assign fracField = halfIn[HALF_FRAC_W-1:0];
  assign lz        = lzCount(fracField);
  assign subFrac   = fracField << (lz + 1'b1);
  assign subExp    = SGL_EXP_W'(BIAS_GAP) - SGL_EXP_W'(lz);
  assign normExp   = SGL_EXP_W'(expField) + SGL_EXP_W'(BIAS_GAP);

  always_comb begin
    unique case (strobes.kind)
      KIND_ZERO: resultD = {signBit, {(SGL_W-1){1'b0}}};
      KIND_SUB:  resultD = {signBit, subExp, subFrac, {PAD_W{1'b0}}};
      KIND_INF:  resultD = {signBit, {SGL_EXP_W{1'b1}}, {SGL_FRAC_W{1'b0}}};
      KIND_NAN:  resultD = strobes.defNan ? CANON_NAN :
                   {signBit, {SGL_EXP_W{1'b1}}, 1'b1,
                    fracField[HALF_FRAC_W-2:0], {PAD_W{1'b0}}};
      default:   resultD = {signBit, normExp, fracField, {PAD_W{1'b0}}};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ  <= 1'b0;
      resultQ <= '0;
    end else begin
      validQ <= inValid;
      if (inValid) resultQ <= resultD;
    end
  end

  // R3: a widened subnormal lands on a normal single exponent in its range
  a_r3_sub_range: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strobes.kind == KIND_SUB) |=>
      (resultQ[SGL_W-2 -: SGL_EXP_W] >= SUB_EXP_MIN &&
       resultQ[SGL_W-2 -: SGL_EXP_W] <= SUB_EXP_MAX));

  // R4: a normal input never yields a zero or all-ones single exponent
  a_r4_norm_finite: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strobes.kind == KIND_NORM) |=>
      (resultQ[SGL_W-2 -: SGL_EXP_W] != '0 &&
       resultQ[SGL_W-2 -: SGL_EXP_W] != '1));

  // R6: any NaN output is quiet
  a_r6_nan_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strobes.kind == KIND_NAN) |=>
      (resultQ[SGL_W-2 -: SGL_EXP_W+1] == '1));

  // R7: default-NaN selection forces the canonical pattern
  a_r7_default_nan: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strobes.kind == KIND_NAN && strobes.defNan) |=>
      (resultQ == CANON_NAN));
endmodule

// File: rtl/half_widen.sv
module half_widen
  import half_widen_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [15:0]       halfIn,
  input  logic [31:0]       ctrlWord,
  output logic              outValid,
  output logic [31:0]       singleOut,
  output logic [7:0]        stickyFlags,
  output logic [7:0]        trapReq
);
  strobe_t strobes;

  half_widen_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .halfIn      (halfIn),
    .ctrlWord    (ctrlWord),
    .strobes     (strobes),
    .stickyFlags (stickyFlags),
    .trapReq     (trapReq)
  );

  half_widen_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .halfIn  (halfIn),
    .strobes (strobes),
    .validQ  (outValid),
    .resultQ (singleOut)
  );
endmodule

// File: tb/tb_half_widen.sv
module tb_half_widen;
  localparam time CLK_PERIOD = 10;
  localparam int  WATCHDOG_CYCLES = 190000;
  localparam int  B_DN = 25;
  localparam int  B_ALT = 26;
  localparam int  B_TRAP = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [15:0] halfIn;
  logic [31:0] ctrlWord;
  logic        outValid;
  logic [31:0] singleOut;
  logic [7:0]  stickyFlags;
  logic [7:0]  trapReq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  bit        expValid = 1'b0;
  bit [31:0] expResult = '0;
  bit [7:0]  expSticky = '0;
  bit [7:0]  expTrap = '0;
  string     expTag = "R1";

  half_widen dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .halfIn(halfIn),
    .ctrlWord(ctrlWord), .outValid(outValid), .singleOut(singleOut),
    .stickyFlags(stickyFlags), .trapReq(trapReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit [31:0] refConv(input bit [15:0] h, input bit alt, input bit dn);
    int s, e, m, ex;
    s = h[15];
    e = h[14:10];
    m = h[9:0];
    if (e == 0 && m == 0) return 32'(s) << 31;
    if (e == 0) begin
      ex = -14;
      while ((m & 'h400) == 0) begin
        m = m * 2;
        ex = ex - 1;
      end
      return (32'(s) << 31) | (32'(ex + 127) << 23) | (32'(m & 'h3FF) << 13);
    end
    if (e == 31 && !alt) begin
      if (m == 0) return (32'(s) << 31) | 32'h7F80_0000;
      if (dn) return 32'h7FC0_0000;
      return (32'(s) << 31) | 32'h7FC0_0000 | (32'(m & 'h1FF) << 13);
    end
    return (32'(s) << 31) | (32'(e + 112) << 23) | (32'(m) << 13);
  endfunction

  function automatic string tagFor(input bit [15:0] h, input bit alt, input bit dn);
    if (h[14:10] == 0) return (h[9:0] == 0) ? "R2" : "R3";
    if (h[14:10] == 31 && !alt) begin
      if (h[9:0] == 0) return "R5";
      return dn ? "R7" : "R6";
    end
    return "R4";
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit [15:0] h, input bit [31:0] c, input bit v);
    bit inv;
    halfIn = h;
    ctrlWord = c;
    inValid = v;
    inv = v && h[14:10] == 31 && !c[B_ALT] && h[9:0] != 0 && !h[9];
    expValid = v;
    if (v) begin
      expResult = refConv(h, c[B_ALT], c[B_DN]);
      expTag = tagFor(h, c[B_ALT], c[B_DN]);
    end else begin
      expTag = "R1";
    end
    expTrap = (inv && c[B_TRAP]) ? 8'h01 : 8'h00;
    if (inv && !c[B_TRAP]) expSticky[0] = 1'b1;
    @(negedge clk);
    check("R1", "outValid", 32'(outValid), 32'(expValid));
    check(expTag, "singleOut", singleOut, expResult);
    check("R8", "stickyFlags", 32'(stickyFlags), 32'(expSticky));
    check("R9", "trapReq", 32'(trapReq), 32'(expTrap));
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    inValid = 1'b0;
    halfIn = '0;
    ctrlWord = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "reset outValid", 32'(outValid), 32'd0);
    check("R1", "reset singleOut", singleOut, 32'd0);
    check("R8", "reset stickyFlags", 32'(stickyFlags), 32'd0);
    check("R9", "reset trapReq", 32'(trapReq), 32'd0);

    // R9: trapped signalling NaN first, sticky must stay clear
    step(16'h7C01, 32'(1) << B_TRAP, 1'b1);
    step(16'h3C00, 32'h0, 1'b1);
    // R2 signed zeros, R3 subnormal extremes
    step(16'h0000, 32'h0, 1'b1);
    step(16'h8000, 32'h0, 1'b1);
    step(16'h0001, 32'h0, 1'b1);
    check("R3", "smallest subnormal", singleOut, 32'h3380_0000);
    step(16'h83FF, 32'h0, 1'b1);
    // R4 normals and alt-format top exponent
    step(16'h7BFF, 32'h0, 1'b1);
    step(16'h7C00, 32'(1) << B_ALT, 1'b1);
    check("R4", "alt top exponent", singleOut, 32'h4780_0000);
    // R1 hold on idle cycle
    step(16'h1234, 32'h0, 1'b0);
    // R5 infinities
    step(16'h7C00, 32'h0, 1'b1);
    step(16'hFC00, 32'h0, 1'b1);
    // R6 quiet NaN payload, R7 default NaN
    step(16'hFE01, 32'h0, 1'b1);
    check("R6", "nan payload", singleOut, 32'hFFC0_2000);
    step(16'h7D55, 32'(1) << B_DN, 1'b1);
    // R8 untrapped signalling NaN sets the sticky bit
    step(16'h7C01, 32'h0, 1'b1);
    step(16'h0000, 32'h0, 1'b1);

    // exhaustive sweeps
    for (int i = 0; i < 65536; i++) step(16'(i), 32'h0, (i % 7) != 3);
    for (int i = 0; i < 65536; i++) step(16'(i), 32'(1) << B_ALT, (i % 5) != 2);
    for (int i = 0; i < 2048; i++)
      step({i[10], 5'h1F, i[9:0]}, 32'(1) << B_DN, 1'b1);
    for (int i = 0; i < 2048; i++)
      step({i[10], 5'h1F, i[9:0]}, (32'(1) << B_TRAP) | (32'(i[0]) << B_DN), 1'b1);
    step(16'h0000, 32'h0, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule